// File: doc/BRIEF.md
# Stereo Serial Audio Port (16-bit, master/slave, three framings)

This block moves 16-bit two's complement stereo samples between a parallel interface and a three-wire serial audio link: a bit clock, a frame clock and one data line in each direction. Capture samples presented on `tx_l`/`tx_r` are shifted out on `sdo`. Playback samples arriving on `sdi` are collected and presented as a left/right pair on `rx_l`/`rx_r` with a one-cycle `rx_valid` strobe. Everything runs in the `clk` domain. The serial clocks are sampled, or generated, against `clk`, and every bit-clock half period must last at least four `clk` cycles.

With `master` high, the block makes the bit clock from the `tick` enable: each tick toggles `bclk_o`, and `lrck_o` changes once every `BCLK_FS/2` bit-clock periods. With `master` low, the block follows the `bclk_i`/`lrck_i` inputs instead. The 2-bit `fmt` field selects the framing. Code 00 sends MSB-justified and receives LSB-justified. Code 01 uses MSB-justified framing both ways. Code 10 uses I2S both ways. Code 11 is reserved. The `loop` flag switches the transmit side to I2S framing.

Each capture channel has its own enable bit. A rising enable starts a muting window of `INIT_FRAMES` frames, during which both transmitted channels carry zero.

Top module: `aport_serial`

## Requirements
- R1: During and right after reset, `sdo`, `bclk_o`, `lrck_o` and `rx_valid` are 0.
- R2: In master mode each `tick` toggles `bclk_o`. `lrck_o` changes only together with a falling `bclk_o`, once every `BCLK_FS/2` bit-clock periods. It is high for the left half except in I2S framing (fmt 10), where it is low for the left half.
- R3: With fmt 01, transmit framing is MSB-justified. The MSB goes out in the first bit slot after a frame-clock change, and the frame-clock-high half carries left. `sdo` changes after falling bit-clock edges.
- R4: With fmt 00, transmit stays MSB-justified. The receiver takes the last 16 bit slots before each frame-clock change, sampled on rising bit-clock edges, MSB first.
- R5: With fmt 01, the receiver takes the first 16 slots after each frame-clock change. Frame clock high means left.
- R6: With fmt 10, both directions use I2S framing: the MSB sits one slot after the frame-clock change, and a low frame clock marks left.
- R7: With `loop` = 1, the transmit framing is I2S whatever `fmt` holds, while the receive framing still follows `fmt`.
- R8: With fmt 11 and `loop` = 0, `sdo` stays 0 and `rx_valid` never pulses.
- R9: `rx_valid` pulses for exactly one `clk` cycle, once per frame, after the right word completes. It requires a left word earlier in the same frame.
- R10: A channel whose enable bit is 0 (`cap_en[0]` for left, `cap_en[1]` for right) transmits 0.
- R11: A 0-to-1 change of either enable bit forces both transmitted channels to 0 for the next `INIT_FRAMES` frames. Afterwards the latched samples go out.
- R12: In slave mode the block frames on `bclk_i`/`lrck_i` and holds `bclk_o`/`lrck_o` at 0.
- R13: At 64fs, the 16 unused slots of each half transmit 0, and whatever `sdi` carries in them is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master | input | 1 | 1: generate serial clocks, 0: follow inputs |
| tick | input | 1 | Master bit-clock toggle enable |
| fmt | input | 2 | Framing code (00, 01, 10, 11 reserved) |
| loop | input | 1 | Force I2S transmit framing |
| cap_en | input | 2 | Capture enables, bit 0 left, bit 1 right |
| tx_l | input | 16 | Left capture sample |
| tx_r | input | 16 | Right capture sample |
| bclk_i | input | 1 | Bit clock in slave mode |
| lrck_i | input | 1 | Frame clock in slave mode |
| sdi | input | 1 | Serial playback data |
| bclk_o | output | 1 | Generated bit clock |
| lrck_o | output | 1 | Generated frame clock |
| sdo | output | 1 | Serial capture data |
| rx_l | output | 16 | Received left sample |
| rx_r | output | 16 | Received right sample |
| rx_valid | output | 1 | One-cycle strobe for a new pair |

## Verification
A slot counter that is off by one shifts every serialized word by one bit. This shows up in the first whole half-frame captured after the frame clock settles, as a doubled or halved value or as a bit leaking into an unused slot. A wrong frame-clock polarity swaps the two channels, or puts the MSB one slot early, within one frame. A stuck muting counter either keeps `sdo` silent long after the expected number of frames or lets data through in the first frame after an enable. A receive window placed wrongly picks up the deliberately non-zero don't-care slots, so the pair strobed at the end of the first frame already differs.

// File: rtl/aport_pkg.sv
package aport_pkg;
   localparam int unsigned SAMPLE_W = 16;

   typedef enum logic [1:0] {
      MODE_TXM_RXL = 2'b00,
      MODE_MSB     = 2'b01,
      MODE_I2S     = 2'b10,
      MODE_RSV     = 2'b11
   } aport_mode_e;

   typedef enum logic [1:0] {
      FR_OFF,
      FR_MSBJ,
      FR_LSBJ,
      FR_I2S
   } aport_frame_e;
endpackage

// File: rtl/aport_clkgen.sv
module aport_clkgen #(
   parameter int unsigned HALF = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   input  logic left_hi,
   output logic bclk,
   output logic lrck
);
   localparam int unsigned CW = $clog2(2 * HALF);
   localparam logic [CW-1:0] C_HALF = CW'(HALF);

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_nxt;

   assign cnt_nxt = cnt + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         bclk <= 1'b0;
         lrck <= 1'b0;
         cnt  <= '1;
      end else if (tick) begin
         bclk <= ~bclk;
         if (bclk) begin
            cnt  <= cnt_nxt;
            lrck <= (cnt_nxt < C_HALF) ? left_hi : ~left_hi;
         end
      end
   end

   p_bclk_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick) |=> (bclk != $past(bclk)));
   p_lrck_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !(tick && bclk)) |=> $stable(lrck));
   p_idle_slave_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!bclk && !lrck));
endmodule

// File: rtl/aport_slot_track.sv
module aport_slot_track #(
   parameter int unsigned HALF = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            ev,
   input  logic                            lr,
   output logic                            lvl,
   output logic [$clog2(HALF+1)-1:0]       slot
);
   localparam int unsigned SW = $clog2(HALF + 1);
   localparam logic [SW-1:0] S_SAT = SW'(HALF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl  <= 1'b0;
         slot <= S_SAT;
      end else if (ev) begin
         if (lr != lvl) begin
            lvl  <= lr;
            slot <= '0;
         end else if (slot != S_SAT) begin
            slot <= slot + 1'b1;
         end
      end
   end

   p_edge_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && lr != lvl) |=> (slot == '0 && lvl == $past(lr)));
   p_slot_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
      slot <= S_SAT);
endmodule

// File: rtl/aport_init_win.sv
module aport_init_win #(
   parameter int unsigned INIT_FRAMES = 2081,
   parameter int unsigned CH          = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CH-1:0] en,
   input  logic          frame_tick,
   output logic          busy
);
   localparam int unsigned CW = $clog2(INIT_FRAMES + 1);

   if (INIT_FRAMES < 1) begin : g_bad_frames
      $error("aport_init_win: INIT_FRAMES must be at least 1");
   end

   logic [CH-1:0] en_q;
   logic [CW-1:0] cnt;
   logic          any_rise;

   assign any_rise = |(en & ~en_q);
   assign busy     = (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
         cnt  <= '0;
      end else begin
         en_q <= en;
         if (any_rise)
            cnt <= CW'(INIT_FRAMES);
         else if (frame_tick && busy)
            cnt <= cnt - 1'b1;
      end
   end

   p_window_opens_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|(en & ~en_q)) |=> busy);
   p_window_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !frame_tick) |=> busy);
endmodule

// File: rtl/aport_rx.sv
module aport_rx
   import aport_pkg::*;
#(
   parameter int unsigned HALF = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ev,
   input  logic                          sdi,
   input  aport_frame_e                  fr,
   input  logic                          left,
   input  logic [$clog2(HALF+1)-1:0]     slot,
   output logic [SAMPLE_W-1:0]           rx_l,
   output logic [SAMPLE_W-1:0]           rx_r,
   output logic                          rx_valid
);
   localparam int unsigned SW = $clog2(HALF + 1);
   localparam logic [SW-1:0] S_W   = SW'(SAMPLE_W);
   localparam logic [SW-1:0] S_WM1 = SW'(SAMPLE_W - 1);
   localparam logic [SW-1:0] S_LO  = SW'(HALF - SAMPLE_W);
   localparam logic [SW-1:0] S_HI  = SW'(HALF - 1);

   logic [SAMPLE_W-2:0] sr;
   logic [SAMPLE_W-1:0] hold;
   logic [SAMPLE_W-1:0] word;
   logic                have_l;
   logic                in_win;
   logic                last;

   assign word = {sr, sdi};

   always_comb begin
      case (fr)
         FR_MSBJ, FR_I2S: begin
            in_win = (slot < S_W);
            last   = (slot == S_WM1);
         end
         FR_LSBJ: begin
            in_win = (slot >= S_LO) && (slot <= S_HI);
            last   = (slot == S_HI);
         end
         default: begin
            in_win = 1'b0;
            last   = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr       <= '0;
         hold     <= '0;
         have_l   <= 1'b0;
         rx_l     <= '0;
         rx_r     <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (ev && in_win) begin
            sr <= word[SAMPLE_W-2:0];
            if (last) begin
               if (left) begin
                  hold   <= word;
                  have_l <= 1'b1;
               end else if (have_l) begin
                  rx_l     <= hold;
                  rx_r     <= word;
                  rx_valid <= 1'b1;
                  have_l   <= 1'b0;
               end
            end
         end
      end
   end

   p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   p_strobe_needs_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(have_l));
   p_rsv_nostrobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fr == FR_OFF) |=> !rx_valid);
endmodule

// File: rtl/aport_serial.sv
module aport_serial
   import aport_pkg::*;
#(
   parameter int unsigned BCLK_FS     = 64,
   parameter int unsigned INIT_FRAMES = 2081
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        master,
   input  logic        tick,
   input  logic [1:0]  fmt,
   input  logic        loop,
   input  logic [1:0]  cap_en,
   input  logic [15:0] tx_l,
   input  logic [15:0] tx_r,
   input  logic        bclk_i,
   input  logic        lrck_i,
   input  logic        sdi,
   output logic        bclk_o,
   output logic        lrck_o,
   output logic        sdo,
   output logic [15:0] rx_l,
   output logic [15:0] rx_r,
   output logic        rx_valid
);
   localparam int unsigned HALF = BCLK_FS / 2;
   localparam int unsigned SW   = $clog2(HALF + 1);
   localparam int unsigned NCH  = 2;
   localparam logic [SW-1:0] S_W = SW'(SAMPLE_W);

   if (BCLK_FS != 32 && BCLK_FS != 64) begin : g_bad_fs
      $error("aport_serial: BCLK_FS must be 32 or 64");
   end

   aport_mode_e  mode;
   aport_frame_e tx_fr, rx_fr;

   assign mode = aport_mode_e'(fmt);

   always_comb begin
      case (mode)
         MODE_TXM_RXL: begin tx_fr = FR_MSBJ; rx_fr = FR_LSBJ; end
         MODE_MSB:     begin tx_fr = FR_MSBJ; rx_fr = FR_MSBJ; end
         MODE_I2S:     begin tx_fr = FR_I2S;  rx_fr = FR_I2S;  end
         default:      begin tx_fr = FR_OFF;  rx_fr = FR_OFF;  end
      endcase
      if (loop) tx_fr = FR_I2S;
   end

   // clock source
   logic bclk_gen, lrck_gen;

   aport_clkgen #(.HALF(HALF)) u_clkgen (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (master),
      .tick   (tick),
      .left_hi(mode != MODE_I2S),
      .bclk   (bclk_gen),
      .lrck   (lrck_gen)
   );

   assign bclk_o = bclk_gen;
   assign lrck_o = lrck_gen;

   // edge detection on the selected serial clocks
   logic b_q, b_qq, l_q, s_q, l_d1, fall_d;
   logic fall_ev, rise_ev;

   assign fall_ev = b_qq & ~b_q;
   assign rise_ev = b_q & ~b_qq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_q    <= 1'b0;
         b_qq   <= 1'b0;
         l_q    <= 1'b0;
         s_q    <= 1'b0;
         l_d1   <= 1'b0;
         fall_d <= 1'b0;
      end else begin
         b_q    <= master ? bclk_gen : bclk_i;
         l_q    <= master ? lrck_gen : lrck_i;
         s_q    <= sdi;
         b_qq   <= b_q;
         fall_d <= fall_ev;
         if (fall_ev) l_d1 <= l_q;
      end
   end

   // slot trackers: direct frame clock and frame clock delayed by one bit
   logic          lvl_a, lvl_b;
   logic [SW-1:0] slot_a, slot_b;

   aport_slot_track #(.HALF(HALF)) u_trk_direct (
      .clk(clk), .rst_n(rst_n), .ev(fall_ev), .lr(l_q), .lvl(lvl_a), .slot(slot_a)
   );
   aport_slot_track #(.HALF(HALF)) u_trk_delayed (
      .clk(clk), .rst_n(rst_n), .ev(fall_ev), .lr(l_d1), .lvl(lvl_b), .slot(slot_b)
   );

   logic [SW-1:0] tx_slot, rx_slot;
   logic          tx_left, rx_left;

   assign tx_slot = (tx_fr == FR_I2S) ? slot_b : slot_a;
   assign tx_left = (tx_fr == FR_I2S) ? ~lvl_b : lvl_a;
   assign rx_slot = (rx_fr == FR_I2S) ? slot_b : slot_a;
   assign rx_left = (rx_fr == FR_I2S) ? ~lvl_b : lvl_a;

   // startup muting window
   logic frame_tick, busy;

   assign frame_tick = fall_d && (slot_a == '0) && lvl_a;

   aport_init_win #(.INIT_FRAMES(INIT_FRAMES), .CH(NCH)) u_init (
      .clk(clk), .rst_n(rst_n), .en(cap_en), .frame_tick(frame_tick), .busy(busy)
   );

   // transmit path
   logic [NCH-1:0][SAMPLE_W-1:0] tx_in, masked, shadow;
   logic [SAMPLE_W-1:0]          cur_word;
   logic                         latch;

   assign tx_in = {tx_r, tx_l};

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      assign masked[ch] = (cap_en[ch] && !busy) ? tx_in[ch] : '0;
   end

   assign latch = fall_d && (tx_slot == '0) && tx_left;

   always_comb begin
      if (tx_left) cur_word = latch ? masked[0] : shadow[0];
      else         cur_word = shadow[1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '0;
         sdo    <= 1'b0;
      end else begin
         if (latch) shadow <= masked;
         if (fall_d)
            sdo <= (tx_fr != FR_OFF && tx_slot < S_W) ? cur_word[~tx_slot[3:0]] : 1'b0;
      end
   end

   // receive path
   aport_rx #(.HALF(HALF)) u_rx (
      .clk(clk), .rst_n(rst_n), .ev(rise_ev), .sdi(s_q), .fr(rx_fr),
      .left(rx_left), .slot(rx_slot), .rx_l(rx_l), .rx_r(rx_r), .rx_valid(rx_valid)
   );

   p_rsv_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_d && tx_fr == FR_OFF) |=> !sdo);
   p_late_slot_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_d && tx_slot >= S_W) |=> !sdo);
   p_init_mute_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && busy) |=> !sdo);
   p_off_chan_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && !cap_en[0]) |=> !sdo);
   p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_d |=> $stable(sdo));
endmodule

// File: tb/aport_serial_test.sv
module aport_serial_test;
   localparam int unsigned FS    = 64;
   localparam int unsigned HALF  = FS / 2;
   localparam int unsigned LIMIT = 200000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic master = 1'b1;
   logic tick = 1'b0;
   logic [1:0] fmt = 2'b01;
   logic loop = 1'b0;
   logic [1:0] cap_en = 2'b11;
   logic [15:0] tx_l = 16'hC35A;
   logic [15:0] tx_r = 16'h1E87;
   logic sb_clk = 1'b0;
   logic sb_lr = 1'b0;
   logic sdi = 1'b0;
   logic bclk_o, lrck_o, sdo, rx_valid;
   logic [15:0] rx_l, rx_r;

   always #2.5 clk = ~clk;

   aport_serial #(.BCLK_FS(FS), .INIT_FRAMES(3)) uut (
      .clk(clk), .rst_n(rst_n), .master(master), .tick(tick), .fmt(fmt), .loop(loop),
      .cap_en(cap_en), .tx_l(tx_l), .tx_r(tx_r), .bclk_i(sb_clk), .lrck_i(sb_lr),
      .sdi(sdi), .bclk_o(bclk_o), .lrck_o(lrck_o), .sdo(sdo), .rx_l(rx_l), .rx_r(rx_r),
      .rx_valid(rx_valid)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // bench-side link model state
   int cyc = 0, tcnt = 0, sb_cnt = 0, idx = 0, halves = 0;
   int nvalid = 0, vlong = 0;
   int per_bc = 0, per_lr = 0, t_bc = 0, t_lr = 0;
   logic pb = 1'b0, plr = 1'b0, pbo = 1'b0, plo = 1'b0, pv = 1'b0;
   logic bc, lr;
   logic [31:0] sh = '0;
   logic [31:0] cap [2];
   logic [31:0] pat [2];
   logic [15:0] got_l = '0, got_r = '0;

   always @(negedge clk) begin
      cyc++;
      tcnt = (tcnt + 1) % 4;
      tick = (tcnt == 0);
      if (tcnt == 0) begin
         if (sb_clk) begin
            sb_cnt = (sb_cnt + 1) % FS;
            sb_lr  = (sb_cnt < HALF) ? (fmt != 2'b10) : (fmt == 2'b10);
         end
         sb_clk = ~sb_clk;
      end
      bc = master ? bclk_o : sb_clk;
      lr = master ? lrck_o : sb_lr;
      if (bc && !pb) sh = {sh[30:0], sdo};
      if (!bc && pb) begin
         if (lr != plr) begin
            cap[plr] = sh;
            halves++;
            idx = 0;
            plr = lr;
         end else if (idx < 31) idx++;
         sdi = pat[lr][31-idx];
      end
      pb = bc;
      if (bclk_o != pbo) begin per_bc = cyc - t_bc; t_bc = cyc; pbo = bclk_o; end
      if (lrck_o != plo) begin per_lr = cyc - t_lr; t_lr = cyc; plo = lrck_o; end
      if (rx_valid) begin
         got_l = rx_l;
         got_r = rx_r;
         nvalid++;
         if (pv) vlong++;
      end
      pv = rx_valid;
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wait_halves(int n);
      int target = halves + n;
      while (halves < target) @(negedge clk);
   endtask

   task automatic set_rx_msb();
      pat[1] = {16'h9D2B, 16'h6CF0};
      pat[0] = {16'h4E71, 16'hB3B3};
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1", "sdo in reset", 32'(sdo), 32'd0);
      chk("R1", "bclk_o in reset", 32'(bclk_o), 32'd0);
      chk("R1", "lrck_o in reset", 32'(lrck_o), 32'd0);
      chk("R1", "rx_valid in reset", 32'(rx_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "sdo after reset", 32'(sdo), 32'd0);
   endtask

   task automatic t_clocks();
      wait_halves(4);
      chk("R2", "bclk half period", 32'(per_bc), 32'd4);
      chk("R2", "lrck half period", 32'(per_lr), 32'(HALF * 8));
   endtask

   task automatic t_mode01();
      int v0;
      fmt = 2'b01; loop = 1'b0; set_rx_msb();
      wait_halves(8);
      chk("R3", "left half msb-justified", cap[1], {tx_l, 16'h0});
      chk("R3", "right half msb-justified", cap[0], {tx_r, 16'h0});
      chk("R5", "rx left msb-justified", 32'(got_l), 32'h9D2B);
      chk("R13", "rx right ignores unused slots", 32'(got_r), 32'h4E71);
      v0 = nvalid;
      wait_halves(8);
      chk("R9", "one strobe per frame", 32'(nvalid - v0), 32'd4);
      chk("R9", "strobe width", 32'(vlong), 32'd0);
   endtask

   task automatic t_mode00();
      fmt = 2'b00;
      pat[1] = {16'h5A5A, 16'h8001};
      pat[0] = {16'hA3C5, 16'h7FFE};
      wait_halves(6);
      chk("R4", "tx stays msb-justified", cap[1], {tx_l, 16'h0});
      chk("R4", "rx left lsb-justified", 32'(got_l), 32'h8001);
      chk("R4", "rx right lsb-justified", 32'(got_r), 32'h7FFE);
   endtask

   task automatic t_i2s();
      fmt = 2'b10;
      pat[0] = {1'b1, 16'h2468, 15'h7FFF};
      pat[1] = {1'b0, 16'hF00D, 15'h0};
      wait_halves(8);
      chk("R6", "i2s left in low half", cap[0], {1'b0, tx_l, 15'h0});
      chk("R6", "i2s right in high half", cap[1], {1'b0, tx_r, 15'h0});
      chk("R6", "rx i2s left", 32'(got_l), 32'h2468);
      chk("R6", "rx i2s right", 32'(got_r), 32'hF00D);
   endtask

   task automatic t_loop();
      fmt = 2'b01; loop = 1'b1; set_rx_msb();
      wait_halves(8);
      chk("R7", "loop tx left i2s", cap[0], {1'b0, tx_l, 15'h0});
      chk("R7", "loop tx right i2s", cap[1], {1'b0, tx_r, 15'h0});
      chk("R7", "loop rx still msb", 32'(got_l), 32'h9D2B);
      loop = 1'b0;
   endtask

   task automatic t_rsv();
      int v0;
      fmt = 2'b11;
      wait_halves(2);
      v0 = nvalid;
      wait_halves(6);
      chk("R8", "reserved sdo high half", cap[1], 32'h0);
      chk("R8", "reserved sdo low half", cap[0], 32'h0);
      chk("R8", "reserved no strobe", 32'(nvalid - v0), 32'd0);
      fmt = 2'b01;
   endtask

   task automatic t_init();
      cap_en = 2'b00;
      wait_halves(6);
      chk("R10", "both disabled left", cap[1], 32'h0);
      chk("R10", "both disabled right", cap[0], 32'h0);
      cap_en = 2'b11;
      wait_halves(4);
      chk("R11", "window mutes left", cap[1], 32'h0);
      chk("R11", "window mutes right", cap[0], 32'h0);
      wait_halves(14);
      chk("R11", "left after window", cap[1], {tx_l, 16'h0});
      chk("R11", "right after window", cap[0], {tx_r, 16'h0});
   endtask

   task automatic t_disable();
      tx_l = 16'h7A31; tx_r = 16'h85CE;
      cap_en = 2'b01;
      wait_halves(6);
      chk("R10", "enabled left sent", cap[1], {16'h7A31, 16'h0});
      chk("R10", "disabled right zero", cap[0], 32'h0);
      cap_en = 2'b11;
      wait_halves(12);
   endtask

   task automatic t_slave();
      master = 1'b0; fmt = 2'b01; set_rx_msb();
      tx_l = 16'h0F1E; tx_r = 16'hE1F0;
      wait_halves(8);
      chk("R12", "slave bclk_o idle", 32'(bclk_o), 32'd0);
      chk("R12", "slave lrck_o idle", 32'(lrck_o), 32'd0);
      chk("R12", "slave tx left", cap[1], {16'h0F1E, 16'h0});
      chk("R12", "slave tx right", cap[0], {16'hE1F0, 16'h0});
      chk("R12", "slave rx left", 32'(got_l), 32'h9D2B);
      chk("R12", "slave rx right", 32'(got_r), 32'h4E71);
   endtask

   initial begin
      cap[0] = '0; cap[1] = '0;
      set_rx_msb();
      t_reset();
      t_clocks();
      t_mode01();
      t_mode00();
      t_i2s();
      t_loop();
      t_rsv();
      t_init();
      t_disable();
      t_slave();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (LIMIT) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule